// File: doc/BRIEF.md
# Codec Power-Down Sequencer

This block decides whether the digital core of a voice-band codec is powered down, waking, or fully active. It runs on the transmit master clock and watches three asynchronous inputs: a combined power-down/receive-clock pin, and the transmit and receive frame-sync inputs. Each input passes through a two-flop synchronizer before any decision is made.

The block comes out of reset powered down. It wakes when the pin is low or toggling like a clock and a frame-sync edge arrives. A pin that toggles within a programmable window of cycles counts as a clock. A pin that sits high forces power-down. Frame-sync inactivity also forces power-down once a programmable cycle count expires. After wake-up the PCM output enable stays off until the second transmit frame-sync edge, so the first transmitted word is never driven from a stale encode cycle.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset the state is power-down: `state_o` = 2'b00, `core_en_o` = 0 and `pcm_oe_o` = 0.
- R2: While the power-down pin is a static high level, frame-sync pulses do not wake the block; `state_o` stays 2'b00.
- R3: With the pin low in power-down, a rising edge on either frame sync moves the block to waking: `state_o` = 2'b01, `core_en_o` = 1, `pcm_oe_o` = 0. The block never goes straight from power-down to active.
- R4: A pin that shows an edge within every `TOGGLE_WIN` master-clock cycles counts as a clock, and it permits wake-up in the same way as a low level.
- R5: `pcm_oe_o` rises, and `state_o` becomes 2'b10 (active), only on the second transmit frame-sync rising edge counted since leaving power-down. The edge that caused the wake-up counts as the first.
- R6: Receive frame-sync edges can wake the block, but they never advance waking to active.
- R7: From waking or active, a pin held high with no edge for `TOGGLE_WIN` cycles returns the block to power-down.
- R8: If no rising edge arrives on either frame sync for `IDLE_TIMEOUT` cycles, the block returns to power-down. Every frame-sync rising edge restarts this count.
- R9: `pcm_oe_o` is never high while `core_en_o` is low, and `state_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit master clock |
| rst_ni | input | 1 | Active-low reset, models power-on reset |
| pdn_pin_i | input | 1 | Combined power-down / receive master clock pin (async) |
| fsx_i | input | 1 | Transmit frame sync (async) |
| fsr_i | input | 1 | Receive frame sync (async) |
| core_en_o | output | 1 | Enable for core and analog output stages |
| pcm_oe_o | output | 1 | PCM data output enable qualifier |
| state_o | output | 2 | 00 power-down, 01 waking, 10 active |

## Verification
A wrong state register shows on `state_o` and on the two enables on the very next clock edge. A wrong transmit-sync count makes `pcm_oe_o` rise one frame early or late, and this is visible within a few cycles of the frame-sync edge. The idle timer and toggle window cannot be seen directly. A fault in either shows only as power-down arriving too early, too late or never, so the checks watch for power-down a fixed margin on each side of those windows.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic [1:0] {
    PS_DOWN   = 2'b00,
    PS_WAKE   = 2'b01,
    PS_ACTIVE = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
  parameter int WIDTH = 1,
  parameter bit BOTH  = 1'b0   // 1: any edge, 0: rising only
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  if (BOTH) begin : g_both
    assign edge_o = sig_i ^ prev_q;
  end else begin : g_rise
    assign edge_o = sig_i & ~prev_q;
  end
endmodule

// File: rtl/pwr_sat_timer.sv
// Saturating up-counter; restart clears it, done when it reaches LIMIT.
module pwr_sat_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] MAX = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= MAX;   // starts expired
    else if (restart_i)   cnt_q <= '0;
    else if (cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == MAX);
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int IDLE_TIMEOUT = 4096,
  parameter int TOGGLE_WIN   = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pdn_pin_i,
  input  logic       fsx_i,
  input  logic       fsr_i,
  output logic       core_en_o,
  output logic       pcm_oe_o,
  output logic [1:0] state_o
);
  logic [2:0] raw_in, sync_in;
  logic       pdn_s, pdn_edge, pin_static, idle_done;
  logic [1:0] fs_rise;
  logic       fsx_rise, fs_any_rise, pin_ok;

  assign raw_in = {pdn_pin_i, fsr_i, fsx_i};

  pwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(sync_in)
  );

  assign pdn_s = sync_in[2];

  pwr_edge_det #(.WIDTH(2), .BOTH(1'b0)) u_fs_edge (
    .clk_i, .rst_ni, .sig_i(sync_in[1:0]), .edge_o(fs_rise)
  );

  pwr_edge_det #(.WIDTH(1), .BOTH(1'b1)) u_pin_edge (
    .clk_i, .rst_ni, .sig_i(pdn_s), .edge_o(pdn_edge)
  );

  // pin is "static" once no edge seen for TOGGLE_WIN cycles
  pwr_sat_timer #(.LIMIT(TOGGLE_WIN)) u_toggle_win (
    .clk_i, .rst_ni, .restart_i(pdn_edge), .done_o(pin_static)
  );

  assign fsx_rise    = fs_rise[0];
  assign fs_any_rise = |fs_rise;

  pwr_sat_timer #(.LIMIT(IDLE_TIMEOUT)) u_idle (
    .clk_i, .rst_ni, .restart_i(fs_any_rise), .done_o(idle_done)
  );

  // low level or clocking pin permits power-up
  assign pin_ok = !pdn_s || !pin_static;

  pwr_state_e state_q, state_d;
  logic       fsx_seen_q, fsx_seen_d;

  always_comb begin
    state_d    = state_q;
    fsx_seen_d = fsx_seen_q;
    unique case (state_q)
      PS_DOWN: begin
        fsx_seen_d = 1'b0;
        if (pin_ok && fs_any_rise) begin
          state_d    = PS_WAKE;
          fsx_seen_d = fsx_rise;
        end
      end
      PS_WAKE: begin
        if (!pin_ok || idle_done) begin
          state_d = PS_DOWN;
        end else if (fsx_rise) begin
          if (fsx_seen_q) state_d = PS_ACTIVE;
          fsx_seen_d = 1'b1;
        end
      end
      PS_ACTIVE: begin
        if (!pin_ok || idle_done) state_d = PS_DOWN;
      end
      default: state_d = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_DOWN;
      fsx_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      fsx_seen_q <= fsx_seen_d;
    end
  end

  assign state_o   = state_q;
  assign core_en_o = (state_q != PS_DOWN);
  assign pcm_oe_o  = (state_q == PS_ACTIVE);
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
  parameter int IDLE_TIMEOUT = 4096,
  parameter int TOGGLE_WIN   = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pdn_pin_i,
  input logic       fsx_i,
  input logic       fsr_i,
  input logic       core_en_o,
  input logic       pcm_oe_o,
  input logic [1:0] state_o
);
  localparam int IDLE_LIM = IDLE_TIMEOUT + 5;
  localparam int HIGH_LIM = TOGGLE_WIN + 6;

  logic fsx_q, fsr_q;
  int   idle_cnt, high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsx_q <= 1'b0; fsr_q <= 1'b0; idle_cnt <= 0; high_cnt <= 0;
    end else begin
      fsx_q <= fsx_i;
      fsr_q <= fsr_i;
      if ((fsx_i && !fsx_q) || (fsr_i && !fsr_q)) idle_cnt <= 0;
      else if (idle_cnt < IDLE_LIM)              idle_cnt <= idle_cnt + 1;
      if (!pdn_pin_i)             high_cnt <= 0;
      else if (high_cnt < HIGH_LIM) high_cnt <= high_cnt + 1;
    end
  end

  p_oe_needs_core_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_oe_o |-> core_en_o);
  p_no_code_11_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  p_wake_before_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_en_o) |-> state_o == 2'b01);
  p_oe_from_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pcm_oe_o) |-> $past(state_o) == 2'b01);
  p_idle_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt > IDLE_TIMEOUT + 4) |-> !core_en_o);
  p_static_high_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_cnt > TOGGLE_WIN + 5) |-> !core_en_o);
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(
  .IDLE_TIMEOUT(IDLE_TIMEOUT), .TOGGLE_WIN(TOGGLE_WIN)
) u_chk (.*);

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 200;
  localparam int WIN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pdn = 1'b1, fsx = 1'b0, fsr = 1'b0;
  logic core_en, pcm_oe;
  logic [1:0] st;
  logic toggle_en = 1'b0;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_pwr_seq #(.IDLE_TIMEOUT(TO), .TOGGLE_WIN(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pdn_pin_i(pdn), .fsx_i(fsx), .fsr_i(fsr),
    .core_en_o(core_en), .pcm_oe_o(pcm_oe), .state_o(st)
  );

  always @(negedge clk) begin
    if (toggle_en) begin
      if ($urandom_range(1, 0) == 1) pdn <= ~pdn;
    end
  end

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs {core_en, pcm_oe, state} expectation for a state code
  function automatic logic [3:0] exp_outs(logic [1:0] s);
    return {s != 2'b00, s == 2'b10, s};
  endfunction

  function automatic logic [1:0] exp_after_gap(int gap);
    return (gap < TO - 20) ? 2'b10 : 2'b00;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fsx();
    @(negedge clk) fsx = 1'b1; idle(2); fsx = 1'b0; idle(6);
  endtask

  task automatic pulse_fsr();
    @(negedge clk) fsr = 1'b1; idle(2); fsr = 1'b0; idle(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    @(negedge clk);
    chk("R1 during reset", {core_en, pcm_oe, st}, exp_outs(2'b00));
    rst_n = 1'b1;
    idle(2);
    chk("R1", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // static high pin blocks wake
    idle(WIN + 10);
    pulse_fsx(); pulse_fsr(); pulse_fsx();
    chk("R2", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // pin low, first transmit sync wakes
    pdn = 1'b0; idle(10);
    pulse_fsx();
    chk("R3", {core_en, pcm_oe, st}, exp_outs(2'b01));
    pulse_fsx();
    chk("R5 second fsx", {core_en, pcm_oe, st}, exp_outs(2'b10));

    // static high pin powers down
    pdn = 1'b1; idle(WIN + 10);
    chk("R7 active->down", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // receive sync wakes but does not advance
    pdn = 1'b0; idle(WIN + 5);
    pulse_fsr();
    chk("R3 fsr wake", {core_en, pcm_oe, st}, exp_outs(2'b01));
    pulse_fsr(); pulse_fsr();
    chk("R6", {core_en, pcm_oe, st}, exp_outs(2'b01));
    pulse_fsx();
    chk("R5 first fsx after fsr wake", {core_en, pcm_oe, st}, exp_outs(2'b01));
    pulse_fsx();
    chk("R5", {core_en, pcm_oe, st}, exp_outs(2'b10));
    chk("R9", {2'b00, pcm_oe & ~core_en, 1'b0}, 4'h0);

    // idle restart then expiry
    idle(TO - 50);
    pulse_fsr();
    idle(TO - 50);
    chk("R8 restart", {core_en, pcm_oe, st}, exp_outs(2'b10));
    idle(TO + 20);
    chk("R8 expiry", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // waking state also times out
    pulse_fsx();
    chk("R3 rewake", {core_en, pcm_oe, st}, exp_outs(2'b01));
    idle(TO + 20);
    chk("R8 wake timeout", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // toggling pin acts as clock
    pdn = 1'b1; idle(WIN + 10);
    toggle_en = 1'b1;
    idle(10);
    pulse_fsx(); pulse_fsx();
    chk("R4", {core_en, pcm_oe, st}, exp_outs(2'b10));
    toggle_en = 1'b0;
    @(negedge clk) pdn = 1'b1;
    idle(WIN + 10);
    chk("R7 after toggling", {core_en, pcm_oe, st}, exp_outs(2'b00));

    // random gaps against idle timeout
    pdn = 1'b0; idle(5);
    pulse_fsx(); pulse_fsx();
    for (int i = 0; i < 24; i++) begin
      int gap;
      gap = ($urandom_range(1, 0) == 1) ? $urandom_range(TO - 60, 20)
                                        : $urandom_range(TO + 150, TO + 30);
      idle(gap);
      chk("R8 random gap", {core_en, pcm_oe, st}, exp_outs(exp_after_gap(gap)));
      if (exp_after_gap(gap) == 2'b00) begin
        pulse_fsx();
        chk("R3 random rewake", {core_en, pcm_oe, st}, exp_outs(2'b01));
        pulse_fsx();
        chk("R5 random", {core_en, pcm_oe, st}, exp_outs(2'b10));
      end else begin
        pulse_fsx();
      end
    end
    finish_run();
  end
endmodule